// File: doc/BRIEF.md
# Interrupt-Capable Parallel I/O Port

This block is a 32-pin general-purpose I/O port that sits on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin has three pieces of state:

- a direction bit;
- an output latch that drives the pad when the pin is an output;
- a synchronized input sample that software can read.

The output latch can be changed bit by bit without a read-modify-write sequence. A write to the set alias raises the selected bits, and a write to the clear alias lowers them.

Each pin can raise an interrupt from any mix of four trigger sources: input low, input high, a rising transition and a falling transition. Each source has its own enable register. A detection from any enabled source latches a per-pin pending bit, and software clears that bit by writing a one to it. The pending bits are ANDed with an interrupt mask, and a single interrupt line reports whether any unmasked pin is pending. Like the output latch, the mask is changed through separate set and clear aliases.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input). The output latch, mask, pending bits and all trigger enables read zero, and `irq_o` is low.
- R2: The direction register at offset 0x134 is written whole. `pin_oe_o` is its bitwise inverse: a direction bit of 1 means input and disables the driver. `pin_o` always equals the output latch, which is written whole at offset 0x13C.
- R3: A write to offset 0x194 sets each latch bit written as 1. A write to offset 0x190 clears each latch bit written as 1. Bits written as 0 keep their value. Reads at 0x13C, 0x190 and 0x194 all return the latch.
- R4: A write to offset 0x034 sets the mask bits written as 1, and a write to offset 0x038 clears them. Reads at either offset return the mask.
- R5: A read at offset 0x138 returns the pin inputs after a two-flop synchronizer. A pin change becomes visible after the second rising clock edge, and writes to this offset have no effect.
- R6: With the rising enable at offset 0x148 set, a 0-to-1 change of the synchronized input marks the pin pending. With the falling enable at offset 0x14C set, a 1-to-0 change marks it pending. With both set, either change marks it pending.
- R7: With the low-level enable at offset 0x140 set, the pin is marked pending on every cycle its synchronized input is 0. With the high-level enable at offset 0x144 set, it is marked pending on every cycle the input is 1. With both set, the pin is always pending.
- R8: Reading offset 0x02C returns the pending bits. Writing a 1 clears that bit and writing a 0 leaves it unchanged. A detection in the same cycle as the clear wins, so a level still present is pending again at once.
- R9: `irq_o` is high exactly when some pin is both pending and unmasked. Pending bits are recorded whether or not the pin is masked.
- R10: The four trigger-enable registers read back what was written. Reads at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte offset |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_i | input | 32 | Pad input levels, asynchronous |
| pin_o | output | 32 | Output latch to the pad drivers |
| pin_oe_o | output | 32 | Driver enable per pin, 1 = drive |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bound checker watches four rules on every cycle:

- the latch and driver-enable outputs follow each set, clear and direction write on the next cycle;
- a full mask clear silences the interrupt line;
- every detection appears in the pending register one cycle later, even across a clear;
- a clear removes every bit that was not re-detected.

Only the bench scenarios can show the rest: the two-edge synchronizer latency, whether a transition on a given input counts as rising, falling or both, level re-triggering after a clear, the always-pending pair of level enables, and the masking of pins that are pending.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;
  typedef logic [ADDR_W-1:0] addr_t;

  // byte offsets decoded by software
  localparam addr_t OFS_STATUS   = 12'h02C;
  localparam addr_t OFS_EN_SET   = 12'h034;
  localparam addr_t OFS_EN_CLR   = 12'h038;
  localparam addr_t OFS_DIR      = 12'h134;
  localparam addr_t OFS_DIN      = 12'h138;
  localparam addr_t OFS_DOUT     = 12'h13C;
  localparam addr_t OFS_LVL_LO   = 12'h140;
  localparam addr_t OFS_LVL_HI   = 12'h144;
  localparam addr_t OFS_RISE     = 12'h148;
  localparam addr_t OFS_FALL     = 12'h14C;
  localparam addr_t OFS_DOUT_CLR = 12'h190;
  localparam addr_t OFS_DOUT_SET = 12'h194;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];
  logic [NUM_PINS-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pin_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // one-cycle history for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign cur_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] lo_en_i,
  input  logic [NUM_PINS-1:0] hi_en_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  output logic [NUM_PINS-1:0] hit_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic lvl_lo, lvl_hi, edge_up, edge_dn;
      assign lvl_lo  = lo_en_i[g]   & ~cur_i[g];
      assign lvl_hi  = hi_en_i[g]   &  cur_i[g];
      assign edge_up = rise_en_i[g] &  cur_i[g] & ~prev_i[g];
      assign edge_dn = fall_en_i[g] & ~cur_i[g] &  prev_i[g];
      assign hit_o[g] = lvl_lo | lvl_hi | edge_up | edge_dn;
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  addr_t               addr_i,
  input  logic                we_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] din_i,
  input  logic [NUM_PINS-1:0] hit_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_PINS-1:0] lo_en_o,
  output logic [NUM_PINS-1:0] hi_en_o,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] status_o
);
  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] dir_q, dout_q, lo_q, hi_q, rise_q, fall_q, mask_q, status_q;
  logic [NUM_PINS-1:0] clr_mask, rsel;

  assign wd = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      dout_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_DIR:      dir_q  <= wd;
        OFS_DOUT:     dout_q <= wd;
        OFS_DOUT_SET: dout_q <= dout_q | wd;
        OFS_DOUT_CLR: dout_q <= dout_q & ~wd;
        OFS_LVL_LO:   lo_q   <= wd;
        OFS_LVL_HI:   hi_q   <= wd;
        OFS_RISE:     rise_q <= wd;
        OFS_FALL:     fall_q <= wd;
        OFS_EN_SET:   mask_q <= mask_q | wd;
        OFS_EN_CLR:   mask_q <= mask_q & ~wd;
        default: ;
      endcase
    end
  end

  // write-one-to-clear; a fresh detection overrides the clear
  assign clr_mask = (we_i && addr_i == OFS_STATUS) ? wd : '0;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_status
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_q[g] <= 1'b0;
        else status_q[g] <= hit_i[g] | (status_q[g] & ~clr_mask[g]);
      end
    end
  endgenerate

  always_comb begin
    unique case (addr_i)
      OFS_STATUS:                          rsel = status_q;
      OFS_EN_SET, OFS_EN_CLR:              rsel = mask_q;
      OFS_DIR:                             rsel = dir_q;
      OFS_DIN:                             rsel = din_i;
      OFS_DOUT, OFS_DOUT_SET, OFS_DOUT_CLR: rsel = dout_q;
      OFS_LVL_LO:                          rsel = lo_q;
      OFS_LVL_HI:                          rsel = hi_q;
      OFS_RISE:                            rsel = rise_q;
      OFS_FALL:                            rsel = fall_q;
      default:                             rsel = '0;
    endcase
    rdata_o = '0;
    rdata_o[NUM_PINS-1:0] = rsel;
  end

  assign dir_o     = dir_q;
  assign dout_o    = dout_q;
  assign lo_en_o   = lo_q;
  assign hi_en_o   = hi_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign mask_o    = mask_q;
  assign status_o  = status_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] cur_w, prev_w, hit_w;
  logic [NUM_PINS-1:0] dir_q, dout_q, lo_en, hi_en, rise_en, fall_en, mask_q, status_q;

  gpio_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .cur_o  (cur_w),
    .prev_o (prev_w)
  );

  gpio_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .cur_i     (cur_w),
    .prev_i    (prev_w),
    .lo_en_i   (lo_en),
    .hi_en_i   (hi_en),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .hit_o     (hit_w)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .din_i     (cur_w),
    .hit_i     (hit_w),
    .dir_o     (dir_q),
    .dout_o    (dout_q),
    .lo_en_o   (lo_en),
    .hi_en_o   (hi_en),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .mask_o    (mask_q),
    .status_o  (status_q)
  );

  assign pin_o    = dout_q;
  assign pin_oe_o = ~dir_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [BUS_W-1:0]    wdata_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] hit_w
);
  logic [NUM_PINS-1:0] wd;
  assign wd = wdata_i[NUM_PINS-1:0];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_outputs_R1: assert (pin_o == '0 && pin_oe_o == '0 && !irq_o)
        else $error("outputs not at reset value");
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DIR) |=> (pin_oe_o == ~$past(wd)));

  assert_dout_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DOUT_SET) |=> ((pin_o & $past(wd)) == $past(wd)));

  assert_dout_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DOUT_CLR) |=> ((pin_o & $past(wd)) == '0));

  assert_dout_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == OFS_DOUT_SET || addr_i == OFS_DOUT_CLR))
      |=> ((pin_o & ~$past(wd)) == ($past(pin_o) & ~$past(wd))));

  assert_mask_clear_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_EN_CLR && wd == '1) |=> !irq_o);

  assert_hit_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w != '0) |=> ((status_q & $past(hit_w)) == $past(hit_w)));

  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_STATUS) |=> ((status_q & $past(wd & ~hit_w)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  import gpio_irq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [31:0]       pins = '0;
  logic [31:0]       pin_o, pin_oe_o;
  logic              irq;
  int                n_chk = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq)
  );

  typedef struct packed {
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{12'h13C, 32'hA5A5_0000, 12'h13C, 32'hA5A5_0000},  // R2 whole latch write
    '{12'h194, 32'h0000_00FF, 12'h13C, 32'hA5A5_00FF},  // R3 set alias
    '{12'h190, 32'hA000_000F, 12'h194, 32'h05A5_00F0},  // R3 clear alias
    '{12'h134, 32'hFFFF_0000, 12'h134, 32'hFFFF_0000},  // R2 direction
    '{12'h034, 32'h0000_0F0F, 12'h034, 32'h0000_0F0F},  // R4 mask set
    '{12'h034, 32'hF000_0000, 12'h038, 32'hF000_0F0F},  // R4 set accumulates
    '{12'h038, 32'h0000_0F00, 12'h034, 32'hF000_000F},  // R4 mask clear
    '{12'h148, 32'h1234_5678, 12'h148, 32'h1234_5678},  // R10 rise enable
    '{12'h14C, 32'h8765_4321, 12'h14C, 32'h8765_4321},  // R10 fall enable
    '{12'h144, 32'h0000_0000, 12'h144, 32'h0000_0000},  // R10 high enable
    '{12'h138, 32'hFFFF_FFFF, 12'h138, 32'h0000_0000},  // R5 data-in read only
    '{12'h02C, 32'hFFFF_FFFF, 12'h02C, 32'h0000_0000}   // R8 clear when idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    step(3);
    // R1 reset state
    rd_chk("R1 dir", 12'h134, 32'hFFFF_FFFF);
    rd_chk("R1 dout", 12'h13C, 32'h0);
    rd_chk("R1 mask", 12'h034, 32'h0);
    rd_chk("R1 status", 12'h02C, 32'h0);
    rd_chk("R1 rise", 12'h148, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pin_oe_o", pin_oe_o, 32'h0);
    rst_ni = 1'b1;
    step(1);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd_chk($sformatf("vector %0d", i), VEC[i].ra, VEC[i].exp);
    end
    chk("R2 pin_o", pin_o, 32'h05A5_00F0);
    chk("R2 pin_oe_o", pin_oe_o, 32'h0000_FFFF);

    wr(12'h148, 32'h0);
    wr(12'h14C, 32'h0);
    wr(12'h038, 32'hFFFF_FFFF);
    rd_chk("R4 mask cleared", 12'h034, 32'h0);

    // R5 synchronizer latency
    pins = 32'hC3C3_5A5A;
    addr = 12'h138;
    step(1); #1 chk("R5 after one edge", rdata, 32'h0);
    step(1); #1 chk("R5 after two edges", rdata, 32'hC3C3_5A5A);
    rd_chk("R9 no enables no pending", 12'h02C, 32'h0);
    pins = '0;
    step(3);

    // R6 rising edge, pin 0
    wr(12'h148, 32'h1);
    wr(12'h034, 32'h1);
    pins[0] = 1'b1; step(3);
    rd_chk("R6 rise pending", 12'h02C, 32'h1);
    chk("R9 irq on unmasked", {31'b0, irq}, 32'h1);
    pins[0] = 1'b0; step(3);
    rd_chk("R6 fall ignored on rise-only", 12'h02C, 32'h1);
    wr(12'h02C, 32'h1);
    rd_chk("R8 edge cleared", 12'h02C, 32'h0);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);

    // R6 falling edge, pin 1, masked
    wr(12'h14C, 32'h2);
    pins[1] = 1'b1; step(3);
    rd_chk("R6 rise ignored on fall-only", 12'h02C, 32'h0);
    pins[1] = 1'b0; step(3);
    rd_chk("R6 fall pending", 12'h02C, 32'h2);
    chk("R9 masked pin no irq", {31'b0, irq}, 32'h0);
    wr(12'h034, 32'h2);
    chk("R4 set unmasks", {31'b0, irq}, 32'h1);
    wr(12'h038, 32'h2);
    chk("R4 clear masks", {31'b0, irq}, 32'h0);
    wr(12'h02C, 32'h2);

    // R6 double edge, pin 2
    wr(12'h148, 32'h5);
    wr(12'h14C, 32'h6);
    pins[2] = 1'b1; step(3);
    rd_chk("R6 double rise", 12'h02C, 32'h4);
    wr(12'h02C, 32'h4);
    pins[2] = 1'b0; step(3);
    rd_chk("R6 double fall", 12'h02C, 32'h4);
    wr(12'h02C, 32'h4);

    // R7 high level, pin 3
    wr(12'h144, 32'h8);
    pins[3] = 1'b1; step(3);
    rd_chk("R7 high pending", 12'h02C, 32'h8);
    wr(12'h02C, 32'h8);
    rd_chk("R8 level repends after clear", 12'h02C, 32'h8);
    pins[3] = 1'b0; step(3);
    wr(12'h02C, 32'h8);
    rd_chk("R7 high gone", 12'h02C, 32'h0);

    // R7 low level, pin 4
    wr(12'h140, 32'h10);
    step(1);
    rd_chk("R7 low pending", 12'h02C, 32'h10);
    pins[4] = 1'b1; step(3);
    wr(12'h02C, 32'h10);
    rd_chk("R7 low gone", 12'h02C, 32'h0);

    // R7 both levels, pin 5
    wr(12'h140, 32'h30);
    wr(12'h144, 32'h28);
    step(1);
    rd_chk("R7 both at 0", 12'h02C, 32'h20);
    pins[5] = 1'b1; step(3);
    wr(12'h02C, 32'h20);
    rd_chk("R7 both at 1", 12'h02C, 32'h20);

    // R8 partial clear
    pins[0] = 1'b1; pins[2] = 1'b1; step(3);
    rd_chk("R8 three pending", 12'h02C, 32'h25);
    wr(12'h02C, 32'h1);
    rd_chk("R8 zeros keep", 12'h02C, 32'h24);

    // R9 mask gating
    chk("R9 pending masked", {31'b0, irq}, 32'h0);
    wr(12'h034, 32'h20);
    chk("R9 unmask pending", {31'b0, irq}, 32'h1);
    wr(12'h038, 32'hFFFF_FFFF);
    chk("R9 full clear", {31'b0, irq}, 32'h0);

    // R10 unmapped
    rd_chk("R10 unmapped 0x000", 12'h000, 32'h0);
    rd_chk("R10 unmapped 0x100", 12'h100, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule